// File: doc/BRIEF.md
# Protection Information Tuple Generator

The block builds one end-to-end protection tuple for each logical block in a byte stream. A logical block is made of a fixed number of data bytes. When the tuple is placed at the end of the per-block metadata, the data bytes are followed by the metadata bytes that come before the tuple. The block runs a guard CRC over every byte the guard covers. It then emits a big-endian tuple that holds the guard, an application tag and a reference tag.

Two tuple formats are supported. The narrow format is 8 bytes: a 16-bit guard, a 16-bit application tag and a 32-bit reference tag. The wide format is 16 bytes: a 64-bit guard, a 16-bit application tag and a 48-bit reference tag. A one-cycle configuration strobe loads the format, the placement, the protection type and the starting tags, and it restarts block framing. After that, bytes stream in under a valid/ready handshake. Each finished block produces a one-cycle tuple strobe, and the reference tag then steps to the value for the next block.

Top module: `pi_tuple_gen`

## Requirements
- R1: While reset is held and in the first cycle after reset, `tupleValid` is 0. `inReady` is 0 during reset and 1 after reset whenever `cfgLoad` is low.
- R2: In the narrow format (`cfgWide`=0), the guard is a CRC16 with polynomial 0x8BB7, initial value 0 and no final inversion. It takes each byte most significant bit first. The ASCII bytes "123456789" give 0xD0DB.
- R3: In the wide format (`cfgWide`=1), the guard is a reflected CRC64 with polynomial 0x9A6C9329AC4BC9B5 (reflected form). It starts at all ones and takes each byte least significant bit first, and the result is XORed with all ones. The ASCII bytes "123456789" give 0xAE8B14860A799888.
- R4: With `cfgFirst`=0, a block is BLOCK_BYTES data bytes followed by META_BYTES minus the tuple size bytes of metadata, and the guard covers all of them in arrival order. The tuple size is 8 for narrow and 16 for wide.
- R5: With `cfgFirst`=1, a block is exactly BLOCK_BYTES data bytes, and no metadata byte enters the guard.
- R6: The narrow tuple is put out in `tupleBytes[127:64]` as guard[15:0], application tag, reference tag[31:0], each big-endian, and `tupleBytes[63:0]` is 0. Byte k of the tuple is at bits [127-8k -: 8].
- R7: The wide tuple fills `tupleBytes` as guard[63:0], application tag, reference tag[47:0], each most significant byte first.
- R8: For protection types 1 and 2 (and code 0), the reference tag goes up by one after each block. In the narrow format the tuple carries its low 32 bits, so 0xFFFFFFFF is followed by 0x00000000.
- R9: For protection type 3 (`cfgType`=3), every block carries the same reference tag, the one that was loaded.
- R10: `tupleValid` goes high for exactly one cycle, in the cycle after the last guard-covered byte of a block is accepted. Blocks can follow each other with no idle cycle, because `inReady` stays high.
- R11: The configuration inputs take effect only in a cycle with `cfgLoad` high, and changes at other times are ignored. A load throws away a partly received block and starts a new block with fresh CRC and tags.
- R12: A cycle with `inValid` low moves neither the byte count nor the guard, so idle cycles inside a block do not change the tuple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgLoad | input | 1 | Load configuration and restart framing |
| cfgWide | input | 1 | 1 = 64-bit guard / 48-bit reference tag format |
| cfgFirst | input | 1 | 1 = tuple at metadata offset 0 (no metadata in guard) |
| cfgType | input | 2 | Protection type code; 3 holds the reference tag |
| cfgAppTag | input | 16 | Application tag for every tuple |
| cfgRefTag | input | 48 | Reference tag of the first block |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inReady | output | 1 | Byte accepted when high together with inValid |
| tupleValid | output | 1 | One-cycle strobe: tupleBytes holds a finished tuple |
| tupleBytes | output | 128 | Big-endian tuple, byte 0 in the top bits |

## Verification
The bench checks both CRC variants against their published check values, so a wrong polynomial, wrong bit order or a missing final inversion would show up as a wrong guard. It uses both placements in both formats, which gives blocks of 9, 10 and 18 bytes. A block-length mistake would fire `tupleValid` early or late, or would let metadata into the guard when the tuple is placed first. It drives a narrow stream whose reference tag crosses 0xFFFFFFFF, a type-3 stream, streams with idle cycles inside a block, pin changes with no load strobe, and a reload in the middle of a block. A design that wraps at the wrong width, steps the tag in type 3, counts idle cycles, or keeps stale framing after a reload would put out wrong tuple bytes or strobe in the wrong cycle.

// File: rtl/pi_tuple_pkg.sv
package pi_tuple_pkg;

  localparam logic [15:0] CRC16_POLY = 16'h8BB7;
  localparam logic [63:0] CRC64_POLY_REFL = 64'h9A6C9329AC4BC9B5;
  localparam int NARROW_TUPLE_BYTES = 8;
  localparam int WIDE_TUPLE_BYTES = 16;
  localparam logic [1:0] TYPE_HOLD_REF = 2'd3;

  typedef struct packed {
    logic load;      // configuration captured, framing restarts
    logic take;      // a byte is accepted this cycle
    logic blockEnd;  // the accepted byte is the last guard-covered byte
  } piStrobe_t;

  // One byte, most significant bit first, no reflection.
  function automatic logic [15:0] crc16Step(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] x;
    x = crc ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) begin
      x = x[15] ? ({x[14:0], 1'b0} ^ CRC16_POLY) : {x[14:0], 1'b0};
    end
    return x;
  endfunction

  // One byte, reflected (least significant bit first).
  function automatic logic [63:0] crc64Step(input logic [63:0] crc, input logic [7:0] b);
    logic [63:0] x;
    x = crc ^ {56'h0, b};
    for (int k = 0; k < 8; k++) begin
      x = x[0] ? ((x >> 1) ^ CRC64_POLY_REFL) : (x >> 1);
    end
    return x;
  endfunction

endpackage

// File: rtl/pi_tuple_ctrl.sv
module pi_tuple_ctrl
  import pi_tuple_pkg::*;
#(
  parameter int BLOCK_BYTES = 9,
  parameter int META_BYTES = 17
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cfgLoad,
  input  logic      cfgWide,
  input  logic      cfgFirst,
  input  logic      inValid,
  output logic      inReady,
  output piStrobe_t strobe
);

  localparam int MAX_LEN = BLOCK_BYTES + META_BYTES;
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(BLOCK_BYTES - 1);
  localparam logic [CNT_W-1:0] PRE_NARROW = CNT_W'(META_BYTES - NARROW_TUPLE_BYTES);
  localparam logic [CNT_W-1:0] PRE_WIDE = CNT_W'(META_BYTES - WIDE_TUPLE_BYTES);

  initial begin
    assert (META_BYTES >= WIDE_TUPLE_BYTES && BLOCK_BYTES >= 1)
      else $error("metadata must hold a wide tuple and blocks must be non-empty");
  end

  logic wideQ;
  logic firstQ;
  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] lastIdx;

  assign inReady = !rst && !cfgLoad;

  always_comb begin
    lastIdx = DATA_LAST;
    if (!firstQ) begin
      lastIdx = DATA_LAST + (wideQ ? PRE_WIDE : PRE_NARROW);
    end
  end

  always_comb begin
    strobe.load = cfgLoad && !rst;
    strobe.take = inValid && inReady;
    strobe.blockEnd = strobe.take && (byteCnt == lastIdx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wideQ <= 1'b0;
      firstQ <= 1'b0;
      byteCnt <= '0;
    end else if (strobe.load) begin
      wideQ <= cfgWide;
      firstQ <= cfgFirst;
      byteCnt <= '0;
    end else if (strobe.blockEnd) begin
      byteCnt <= '0;
    end else if (strobe.take) begin
      byteCnt <= byteCnt + 1'b1;
    end
  end

  // R4 / R5: the position never passes the last guard-covered byte
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    byteCnt <= lastIdx);

  // R11: a load restarts framing
  assert_load_restart_R11: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> byteCnt == '0);

  // R12: idle cycles leave the position alone
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!strobe.take && !strobe.load) |=> $stable(byteCnt));

endmodule

// File: rtl/pi_tuple_dp.sv
module pi_tuple_dp
  import pi_tuple_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  piStrobe_t     strobe,
  input  logic          cfgWide,
  input  logic [1:0]    cfgType,
  input  logic [15:0]   cfgAppTag,
  input  logic [47:0]   cfgRefTag,
  input  logic [7:0]    inData,
  output logic          tupleValid,
  output logic [127:0]  tupleBytes
);

  logic wideQ;
  logic [1:0] typeQ;
  logic [15:0] appQ;
  logic [47:0] refQ;
  logic [15:0] crc16Q;
  logic [63:0] crc64Q;
  logic [15:0] crc16Next;
  logic [63:0] crc64Next;
  logic [127:0] tupleNext;
  logic validQ;
  logic [127:0] tupleQ;

  assign crc16Next = crc16Step(crc16Q, inData);
  assign crc64Next = crc64Step(crc64Q, inData);

  always_comb begin
    if (wideQ) begin
      tupleNext = {~crc64Next, appQ, refQ};
    end else begin
      tupleNext = {crc16Next, appQ, refQ[31:0], 64'h0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wideQ <= 1'b0;
      typeQ <= 2'd1;
      appQ <= '0;
      refQ <= '0;
      crc16Q <= '0;
      crc64Q <= '1;
      validQ <= 1'b0;
      tupleQ <= '0;
    end else begin
      validQ <= strobe.blockEnd;
      if (strobe.load) begin
        wideQ <= cfgWide;
        typeQ <= cfgType;
        appQ <= cfgAppTag;
        refQ <= cfgRefTag;
        crc16Q <= '0;
        crc64Q <= '1;
      end else if (strobe.blockEnd) begin
        crc16Q <= '0;
        crc64Q <= '1;
        tupleQ <= tupleNext;
        if (typeQ != TYPE_HOLD_REF) begin
          refQ <= refQ + 48'd1;
        end
      end else if (strobe.take) begin
        crc16Q <= crc16Next;
        crc64Q <= crc64Next;
      end
    end
  end

  assign tupleValid = validQ;
  assign tupleBytes = tupleQ;

  // R10: a tuple follows the last byte one cycle later, and only then
  assert_valid_after_end_R10: assert property (@(posedge clk) disable iff (rst)
    strobe.blockEnd |=> tupleValid);
  assert_valid_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
    tupleValid |-> $past(strobe.blockEnd));

  // R8: the reference tag steps once per block outside type 3
  assert_ref_step_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe.blockEnd && typeQ != TYPE_HOLD_REF) |=> refQ == $past(refQ) + 48'd1);

  // R9: type 3 keeps the reference tag
  assert_ref_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe.blockEnd && typeQ == TYPE_HOLD_REF) |=> $stable(refQ));

  // R11: the application tag only changes on a load
  assert_app_only_on_load_R11: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(appQ));

  // R6: the narrow tuple leaves the lower half empty
  assert_narrow_pad_R6: assert property (@(posedge clk) disable iff (rst)
    (tupleValid && !wideQ) |-> tupleBytes[63:0] == 64'h0);

endmodule

// File: rtl/pi_tuple_gen.sv
module pi_tuple_gen
  import pi_tuple_pkg::*;
#(
  parameter int BLOCK_BYTES = 9,
  parameter int META_BYTES = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfgLoad,
  input  logic          cfgWide,
  input  logic          cfgFirst,
  input  logic [1:0]    cfgType,
  input  logic [15:0]   cfgAppTag,
  input  logic [47:0]   cfgRefTag,
  input  logic          inValid,
  input  logic [7:0]    inData,
  output logic          inReady,
  output logic          tupleValid,
  output logic [127:0]  tupleBytes
);

  piStrobe_t strobe;

  pi_tuple_ctrl #(
    .BLOCK_BYTES(BLOCK_BYTES),
    .META_BYTES(META_BYTES)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .cfgLoad(cfgLoad),
    .cfgWide(cfgWide),
    .cfgFirst(cfgFirst),
    .inValid(inValid),
    .inReady(inReady),
    .strobe(strobe)
  );

  pi_tuple_dp u_dp (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .cfgWide(cfgWide),
    .cfgType(cfgType),
    .cfgAppTag(cfgAppTag),
    .cfgRefTag(cfgRefTag),
    .inData(inData),
    .tupleValid(tupleValid),
    .tupleBytes(tupleBytes)
  );

  // R1: no tuple strobe straight out of reset
  assert_no_valid_after_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> !tupleValid);

endmodule

// File: tb/tb_pi_tuple_gen.sv
module tb_pi_tuple_gen;

  localparam int CLK_PERIOD = 10;
  localparam int BLOCK_BYTES = 9;
  localparam int META_BYTES = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgLoad = 1'b0;
  logic cfgWide = 1'b0;
  logic cfgFirst = 1'b0;
  logic [1:0] cfgType = 2'd1;
  logic [15:0] cfgAppTag = '0;
  logic [47:0] cfgRefTag = '0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inReady;
  logic tupleValid;
  logic [127:0] tupleBytes;

  int nTests = 0;
  int nFails = 0;
  int cycles = 0;

  bit cWide;
  bit cFirst;
  logic [1:0] cType;
  logic [15:0] cApp;
  logic [47:0] cRef;
  logic [7:0] blkBuf [0:63];
  logic [127:0] lastSeen;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pi_tuple_gen #(
    .BLOCK_BYTES(BLOCK_BYTES),
    .META_BYTES(META_BYTES)
  ) dut (
    .clk(clk),
    .rst(rst),
    .cfgLoad(cfgLoad),
    .cfgWide(cfgWide),
    .cfgFirst(cfgFirst),
    .cfgType(cfgType),
    .cfgAppTag(cfgAppTag),
    .cfgRefTag(cfgRefTag),
    .inValid(inValid),
    .inData(inData),
    .inReady(inReady),
    .tupleValid(tupleValid),
    .tupleBytes(tupleBytes)
  );

  function automatic int blockLen();
    if (cFirst) return BLOCK_BYTES;
    return BLOCK_BYTES + META_BYTES - (cWide ? 16 : 8);
  endfunction

  // Bit-serial reference model of both guards and the tuple layout
  function automatic logic [127:0] model(input int len, input bit wide,
                                         input logic [15:0] app, input logic [47:0] refTag);
    logic [15:0] c16;
    logic [63:0] c64;
    bit fb;
    c16 = 16'h0;
    c64 = '1;
    for (int i = 0; i < len; i++) begin
      for (int k = 7; k >= 0; k--) begin
        fb = c16[15] ^ blkBuf[i][k];
        c16 = {c16[14:0], 1'b0};
        if (fb) c16 = c16 ^ 16'h8BB7;
      end
      for (int k = 0; k < 8; k++) begin
        fb = c64[0] ^ blkBuf[i][k];
        c64 = c64 >> 1;
        if (fb) c64 = c64 ^ 64'h9A6C9329AC4BC9B5;
      end
    end
    if (wide) return {~c64, app, refTag};
    return {c16, app, refTag[31:0], 64'h0};
  endfunction

  function automatic logic [7:0] genByte(input int seed, input int blk, input int i);
    if (seed == 0) return 8'h31 + 8'(i);
    return 8'((seed * 37 + blk * 101 + i * 13 + (i * i) * 7) & 8'hFF);
  endfunction

  task automatic checkOut(input bit expV, input logic [127:0] expT, input string tag);
    nTests++;
    if (tupleValid !== expV || (expV && tupleBytes !== expT) || inReady !== 1'b1) begin
      nFails++;
      $display("FAIL %s: valid=%b ready=%b tuple=%h expected valid=%b ready=1 tuple=%h",
               tag, tupleValid, inReady, tupleBytes, expV, expT);
    end
    if (tupleValid === 1'b1) lastSeen = tupleBytes;
  endtask

  task automatic loadCfg(input bit wide, input bit first, input logic [1:0] typ,
                         input logic [15:0] app, input logic [47:0] refTag);
    @(negedge clk);
    cfgWide = wide;
    cfgFirst = first;
    cfgType = typ;
    cfgAppTag = app;
    cfgRefTag = refTag;
    cfgLoad = 1'b1;
    inValid = 1'b0;
    cWide = wide;
    cFirst = first;
    cType = typ;
    cApp = app;
    cRef = refTag;
    @(negedge clk);
    nTests++;
    if (inReady !== 1'b0 || tupleValid !== 1'b0) begin
      nFails++;
      $display("FAIL R11: during load ready=%b valid=%b expected ready=0 valid=0",
               inReady, tupleValid);
    end
    cfgLoad = 1'b0;
  endtask

  // Drives nBlk blocks with optional idle cycles; checks every cycle
  task automatic runBlocks(input int nBlk, input int gapMod, input int seed,
                           input bit scramble, input string tag);
    bit expV;
    logic [127:0] expT;
    logic [127:0] expNext;
    int bl;
    expV = 1'b0;
    expT = '0;
    bl = blockLen();
    for (int b = 0; b < nBlk; b++) begin
      for (int i = 0; i < bl; i++) blkBuf[i] = genByte(seed, b, i);
      expNext = model(bl, cWide, cApp, cRef);
      for (int i = 0; i < bl; i++) begin
        if (gapMod > 0 && (i % gapMod) == 1) begin
          @(negedge clk);
          checkOut(expV, expT, tag);
          expV = 1'b0;
          inValid = 1'b0;
          inData = 8'hA5;
        end
        @(negedge clk);
        checkOut(expV, expT, tag);
        inValid = 1'b1;
        inData = blkBuf[i];
        if (scramble && b == 0 && i == 2) begin
          cfgWide = ~cWide;
          cfgFirst = ~cFirst;
          cfgType = ~cType;
          cfgAppTag = ~cApp;
          cfgRefTag = ~cRef;
        end
        expV = (i == bl - 1);
        if (expV) expT = expNext;
      end
      if (cType != 2'd3) cRef = cRef + 48'd1;
    end
    @(negedge clk);
    checkOut(expV, expT, tag);
    inValid = 1'b0;
    @(negedge clk);
    checkOut(1'b0, expT, tag);
  endtask

  task automatic tReset();
    nTests++;
    if (tupleValid !== 1'b0 || inReady !== 1'b0) begin
      nFails++;
      $display("FAIL R1: in reset valid=%b ready=%b expected valid=0 ready=0", tupleValid, inReady);
    end
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    nTests++;
    if (tupleValid !== 1'b0 || inReady !== 1'b1) begin
      nFails++;
      $display("FAIL R1: after reset valid=%b ready=%b expected valid=0 ready=1", tupleValid, inReady);
    end
  endtask

  task automatic tKnownNarrow();
    loadCfg(1'b0, 1'b1, 2'd1, 16'h1234, 48'h0000_DEAD_BEEF);
    runBlocks(1, 0, 0, 1'b0, "R2 R5 R6 narrow check value");
    nTests++;
    if (lastSeen !== {16'hD0DB, 16'h1234, 32'hDEADBEEF, 64'h0}) begin
      nFails++;
      $display("FAIL R2: tuple=%h expected=%h", lastSeen, {16'hD0DB, 16'h1234, 32'hDEADBEEF, 64'h0});
    end
  endtask

  task automatic tKnownWide();
    loadCfg(1'b1, 1'b1, 2'd1, 16'hBEEF, 48'h0123_4567_89AB);
    runBlocks(1, 0, 0, 1'b0, "R3 R7 wide check value");
    nTests++;
    if (lastSeen !== {64'hAE8B14860A799888, 16'hBEEF, 48'h0123_4567_89AB}) begin
      nFails++;
      $display("FAIL R3: tuple=%h expected=%h", lastSeen,
               {64'hAE8B14860A799888, 16'hBEEF, 48'h0123_4567_89AB});
    end
  endtask

  task automatic tNarrowLastWrap();
    loadCfg(1'b0, 1'b0, 2'd2, 16'hCAFE, 48'h0000_FFFF_FFFE);
    runBlocks(3, 0, 5, 1'b0, "R4 R8 R10 narrow tail placement, tag wrap, back-to-back");
    nTests++;
    if (lastSeen[95:64] !== 32'h0000_0000) begin
      nFails++;
      $display("FAIL R8: wrapped ref=%h expected=00000000", lastSeen[95:64]);
    end
  endtask

  task automatic tWideLastGaps();
    loadCfg(1'b1, 1'b0, 2'd1, 16'h0F0F, 48'hFFFF_FFFF_FFFE);
    runBlocks(3, 3, 9, 1'b0, "R4 R8 R12 wide tail placement with idle cycles");
  endtask

  task automatic tTypeThree();
    loadCfg(1'b0, 1'b1, 2'd3, 16'h5A5A, 48'h0000_1234_5678);
    runBlocks(3, 0, 17, 1'b0, "R9 type 3 narrow");
    loadCfg(1'b1, 1'b0, 2'd3, 16'hA5A5, 48'h7777_0000_0001);
    runBlocks(2, 2, 23, 1'b0, "R9 type 3 wide");
  endtask

  task automatic tPinsIgnored();
    loadCfg(1'b0, 1'b0, 2'd1, 16'h1111, 48'h0000_0000_0010);
    runBlocks(2, 0, 31, 1'b1, "R11 pin changes without load");
  endtask

  task automatic tReloadMidBlock();
    loadCfg(1'b1, 1'b1, 2'd1, 16'h2222, 48'h0000_0000_0100);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      checkOut(1'b0, '0, "R11 partial block");
      inValid = 1'b1;
      inData = 8'(8'hC0 + i);
    end
    loadCfg(1'b0, 1'b1, 2'd2, 16'h3333, 48'h0000_0000_0200);
    runBlocks(2, 0, 41, 1'b0, "R11 reload restarts block");
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nFails++;
        nTests++;
        $display("FAIL watchdog: run did not end, cycles=%0d expected<=100000", cycles);
        $display("[TB] %0d tests run, %0d failed", nTests, nFails);
        $finish;
      end
    end
  end

  initial begin
    cWide = 1'b0;
    cFirst = 1'b0;
    cType = 2'd1;
    cApp = '0;
    cRef = '0;
    lastSeen = '0;
    repeat (3) @(negedge clk);
    tReset();
    tKnownNarrow();
    tKnownWide();
    tNarrowLastWrap();
    tWideLastGaps();
    tTypeThree();
    tPinsIgnored();
    tReloadMidBlock();
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule